// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block decides whether a twisted-pair receive pair has been wired with its conductors swapped. It produces a receive-invert control for the data path and an active-low status indicator. It observes two kinds of single-cycle event strobes. Link pulses arrive already qualified, each tagged with its polarity. End-of-packet events arrive tagged with a flag that says whether the end delimiter was valid, and with the delimiter's polarity. A link monitor supplies a level that is high while the link is failed. A strap input turns correction off.

The polarity decision has two stages. While the link is failed, the block counts runs of link pulses of the same polarity. When the link returns to pass after a long enough run, that run's polarity gives a first guess. From then on, valid end delimiters refine the guess. The first one overrides whatever came before. Later ones replace the setting whenever they disagree with it. Once two valid delimiters in a row agree, the setting locks. It stays locked until the link fails again or the block is reset. While the link is up, the block also tells the link monitor which link pulses to count: only pulses of the currently decided polarity.

There is no back-pressure. Every event is a strobe that is consumed in the cycle it appears, and all pins are plain levels or strobes.

Top module: `rx_polarity_guard`

## Requirements
- R1: The synchronous reset (rst_n low at a rising edge) clears the decision to non-inverted: rx_invert = 0 and pol_led_n = 0. It also restarts detection, with no delimiter decision made.
- R2: While link_fail = 1, every link pulse strobe is reported as accepted on lp_accept in the same cycle, whatever the value of lp_neg.
- R3: While link_fail = 1, a run counter tracks consecutive link pulses of one polarity (lp_neg = 1 means reversed). A pulse of the other polarity restarts the count at one, and entry into link fail clears it. In the first cycle after link_fail falls, if the run is 5 or longer and no delimiter decision exists, rx_invert takes the run's polarity. A shorter run leaves rx_invert unchanged.
- R4: While link_fail = 0, lp_accept is high only for a link pulse whose lp_neg equals the current rx_invert.
- R5: The first end-of-packet event with eop_valid = 1 after reset or link fail sets rx_invert to its eop_neg, whatever the prior setting.
- R6: After that first decision, a valid delimiter whose eop_neg differs from the setting replaces it. A valid delimiter that agrees locks the setting, and later delimiters are then ignored.
- R7: An event with eop_valid = 0 changes neither the polarity nor the armed or locked state, and it does not break a run of agreeing valid delimiters.
- R8: Entry into link fail (link_fail rising) removes any lock, so the next valid delimiter after link pass makes a first decision again.
- R9: End-of-packet events that arrive while link_fail = 1 have no effect.
- R10: While corr_dis = 1, rx_invert is held at 0 and pol_led_n at 0. The internal decision is kept and reappears when corr_dis returns to 0.
- R11: pol_led_n is 0 (drive low) when the polarity in use is normal and 1 (released) when the polarity in use is reversed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_fail | input | 1 | Level from the link monitor, high while the link is failed |
| corr_dis | input | 1 | Strap, 1 disables polarity correction |
| lp_strobe | input | 1 | One-cycle strobe for a qualified link pulse |
| lp_neg | input | 1 | Polarity of the link pulse, 1 = reversed |
| eop_strobe | input | 1 | One-cycle strobe at end of a received packet |
| eop_valid | input | 1 | End delimiter of that packet was valid |
| eop_neg | input | 1 | Polarity of that delimiter, 1 = reversed |
| rx_invert | output | 1 | Invert control for the receive data path |
| pol_led_n | output | 1 | Indicator, 0 = drive low (normal), 1 = released (reversed) |
| lp_accept | output | 1 | Link pulse in this cycle counts as valid for the link monitor |

## Verification
The properties assume single-cycle strobes. They also assume that the link-fail level and the strap never change in the same cycle as a delimiter event. The checks on delimiter effects exclude the cycle of link-pass entry, because the link-pulse guess is loaded at that edge. The bench drives every input only at falling clock edges and raises each strobe for exactly one cycle. It moves link_fail and corr_dis only in cycles with no event, so the stimulus stays inside those assumptions.

// File: rtl/rx_polarity_pkg.sv
package rx_polarity_pkg;

  typedef enum logic [1:0] {
    DEC_SEEK   = 2'd0,
    DEC_ARMED  = 2'd1,
    DEC_LOCKED = 2'd2
  } dec_state_t;

  typedef struct packed {
    logic take;
    logic neg;
  } pol_event_t;

endpackage

// File: rtl/rxp_run_tracker.sv
module rxp_run_tracker #(
  parameter int PASS_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_fail,
  input  logic fail_entry,
  input  logic lp_strobe,
  input  logic lp_neg,
  output logic run_ok,
  output logic run_neg
);
  localparam int RUN_W = $clog2(PASS_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(PASS_RUN);

  logic [RUN_W-1:0] run_cnt;
  logic             run_pol;

  always_ff @(posedge clk) begin
    if (!rst_n || fail_entry) begin
      run_cnt <= '0;
      run_pol <= 1'b0;
    end else if (link_fail && lp_strobe) begin
      if (run_cnt != '0 && lp_neg == run_pol) begin
        if (run_cnt != RUN_CAP) run_cnt <= run_cnt + 1'b1;
      end else begin
        run_pol <= lp_neg;
        run_cnt <= RUN_W'(1);
      end
    end
  end

  assign run_ok  = (run_cnt >= RUN_CAP);
  assign run_neg = run_pol;
endmodule

// File: rtl/rxp_decider.sv
module rxp_decider
  import rx_polarity_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       lp_load,
  input  logic       lp_pol,
  input  pol_event_t etd,
  output logic       pol,
  output logic       undecided
);
  dec_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= DEC_SEEK;
      pol   <= 1'b0;
    end else if (clr) begin
      state <= DEC_SEEK;
    end else if (etd.take) begin
      unique case (state)
        DEC_SEEK: begin
          pol   <= etd.neg;
          state <= DEC_ARMED;
        end
        DEC_ARMED: begin
          if (etd.neg == pol) state <= DEC_LOCKED;
          else                pol   <= etd.neg;
        end
        default: state <= DEC_LOCKED;
      endcase
    end else if (lp_load && state == DEC_SEEK) begin
      pol <= lp_pol;
    end
  end

  assign undecided = (state == DEC_SEEK);
endmodule

// File: rtl/rxp_drive.sv
module rxp_drive (
  input  logic pol,
  input  logic corr_dis,
  input  logic link_fail,
  input  logic lp_strobe,
  input  logic lp_neg,
  output logic rx_invert,
  output logic pol_led_n,
  output logic lp_accept
);
  logic inv_used;

  always_comb begin
    inv_used  = pol & ~corr_dis;
    rx_invert = inv_used;
    pol_led_n = inv_used;
    lp_accept = lp_strobe & (link_fail | (lp_neg == inv_used));
  end
endmodule

// File: rtl/rx_polarity_guard.sv
module rx_polarity_guard
  import rx_polarity_pkg::*;
#(
  parameter int PASS_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_fail,
  input  logic corr_dis,
  input  logic lp_strobe,
  input  logic lp_neg,
  input  logic eop_strobe,
  input  logic eop_valid,
  input  logic eop_neg,
  output logic rx_invert,
  output logic pol_led_n,
  output logic lp_accept
);
  logic       fail_q;
  logic       fail_entry;
  logic       pass_entry;
  logic       run_ok;
  logic       run_neg;
  logic       pol;
  logic       undecided;
  pol_event_t etd;

  always_ff @(posedge clk) begin
    if (!rst_n) fail_q <= 1'b1;
    else        fail_q <= link_fail;
  end

  assign fail_entry = link_fail & ~fail_q;
  assign pass_entry = fail_q & ~link_fail;

  always_comb begin
    etd.take = eop_strobe & eop_valid & ~link_fail;
    etd.neg  = eop_neg;
  end

  rxp_run_tracker #(.PASS_RUN(PASS_RUN)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_fail  (link_fail),
    .fail_entry (fail_entry),
    .lp_strobe  (lp_strobe),
    .lp_neg     (lp_neg),
    .run_ok     (run_ok),
    .run_neg    (run_neg)
  );

  rxp_decider u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (link_fail),
    .lp_load   (pass_entry & run_ok & undecided),
    .lp_pol    (run_neg),
    .etd       (etd),
    .pol       (pol),
    .undecided (undecided)
  );

  rxp_drive u_drv (
    .pol       (pol),
    .corr_dis  (corr_dis),
    .link_fail (link_fail),
    .lp_strobe (lp_strobe),
    .lp_neg    (lp_neg),
    .rx_invert (rx_invert),
    .pol_led_n (pol_led_n),
    .lp_accept (lp_accept)
  );
endmodule

// File: rtl/rx_polarity_guard_checker.sv
module rx_polarity_guard_checker (
  input logic clk,
  input logic rst_n,
  input logic link_fail,
  input logic corr_dis,
  input logic lp_strobe,
  input logic lp_neg,
  input logic eop_strobe,
  input logic eop_valid,
  input logic rx_invert,
  input logic lp_accept
);
  assert_fail_accepts_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fail && lp_strobe) |-> lp_accept);

  assert_pass_accepts_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_fail && lp_accept) |-> (lp_neg == rx_invert));

  assert_invalid_eop_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_strobe && !eop_valid && !link_fail && !$past(link_fail) && !lp_strobe)
      |=> (rx_invert == $past(rx_invert) || corr_dis != $past(corr_dis)));

  assert_fail_eop_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fail && eop_strobe)
      |=> (rx_invert == $past(rx_invert) || corr_dis != $past(corr_dis)));

  assert_strap_forces_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    corr_dis |-> !rx_invert);
endmodule

bind rx_polarity_guard rx_polarity_guard_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .link_fail  (link_fail),
  .corr_dis   (corr_dis),
  .lp_strobe  (lp_strobe),
  .lp_neg     (lp_neg),
  .eop_strobe (eop_strobe),
  .eop_valid  (eop_valid),
  .rx_invert  (rx_invert),
  .lp_accept  (lp_accept)
);

// File: tb/rx_polarity_guard_bench.sv
module rx_polarity_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_fail = 1'b1;
  logic corr_dis = 1'b0;
  logic lp_strobe = 1'b0;
  logic lp_neg = 1'b0;
  logic eop_strobe = 1'b0;
  logic eop_valid = 1'b0;
  logic eop_neg = 1'b0;
  logic rx_invert;
  logic pol_led_n;
  logic lp_accept;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;
    bit    exp;
    string tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  rx_polarity_guard u_rx_polarity_guard (
    .clk(clk), .rst_n(rst_n), .link_fail(link_fail), .corr_dis(corr_dis),
    .lp_strobe(lp_strobe), .lp_neg(lp_neg), .eop_strobe(eop_strobe),
    .eop_valid(eop_valid), .eop_neg(eop_neg), .rx_invert(rx_invert),
    .pol_led_n(pol_led_n), .lp_accept(lp_accept)
  );

  // monitor: compares queued expectations just before each rising edge
  always @(posedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic  act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = rx_invert;
        1:       act = pol_led_n;
        default: act = lp_accept;
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fails++;
        $display("FAIL %s kind=%0d actual=%b expected=%b", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int kind, bit exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_pol(bit e, string tag);
    push(0, e, tag);
    push(1, e, {tag, "/R11"});
  endtask

  task automatic lp(bit neg);
    @(negedge clk); lp_strobe = 1'b1; lp_neg = neg;
    @(negedge clk); lp_strobe = 1'b0;
  endtask

  task automatic lp_chk(bit neg, bit acc, string tag);
    @(negedge clk); lp_strobe = 1'b1; lp_neg = neg;
    push(2, acc, tag);
    @(negedge clk); lp_strobe = 1'b0;
  endtask

  task automatic eop(bit valid, bit neg);
    @(negedge clk); eop_strobe = 1'b1; eop_valid = valid; eop_neg = neg;
    @(negedge clk); eop_strobe = 1'b0;
  endtask

  task automatic set_fail(bit v);
    @(negedge clk); link_fail = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_pol(1'b0, "R1");
    // R2: both polarities accepted while failed
    lp_chk(1'b1, 1'b1, "R2");
    lp_chk(1'b0, 1'b1, "R2");
    // R3: run of six reversed pulses, then pass
    for (int i = 0; i < 6; i++) lp(1'b1);
    set_fail(1'b0);
    exp_pol(1'b1, "R3");
    // R4: only matching polarity counts after pass
    lp_chk(1'b1, 1'b1, "R4");
    lp_chk(1'b0, 1'b0, "R4");
    // R5 / R6
    eop(1'b1, 1'b0); exp_pol(1'b0, "R5");
    eop(1'b1, 1'b1); exp_pol(1'b1, "R6");
    eop(1'b1, 1'b1); exp_pol(1'b1, "R6");
    eop(1'b1, 1'b0); exp_pol(1'b1, "R6");
    lp_chk(1'b0, 1'b0, "R4");
    // R9 and R8 with restarted run (R3)
    set_fail(1'b1);
    eop(1'b1, 1'b0); exp_pol(1'b1, "R9");
    for (int i = 0; i < 3; i++) lp(1'b1);
    for (int i = 0; i < 5; i++) lp(1'b0);
    set_fail(1'b0);
    exp_pol(1'b0, "R3");
    eop(1'b1, 1'b1); exp_pol(1'b1, "R8");
    eop(1'b0, 1'b0); exp_pol(1'b1, "R7");
    eop(1'b1, 1'b1); exp_pol(1'b1, "R7");
    eop(1'b1, 1'b0); exp_pol(1'b1, "R7");
    // R7: invalid delimiter does not count as first decision
    set_fail(1'b1);
    for (int i = 0; i < 5; i++) lp(1'b1);
    set_fail(1'b0);
    exp_pol(1'b1, "R3");
    eop(1'b0, 1'b0); exp_pol(1'b1, "R7");
    eop(1'b1, 1'b0); exp_pol(1'b0, "R7");
    eop(1'b1, 1'b1); exp_pol(1'b1, "R6");
    // R3: short run keeps setting
    set_fail(1'b1);
    for (int i = 0; i < 4; i++) lp(1'b0);
    set_fail(1'b0);
    exp_pol(1'b1, "R3");
    // R10 strap
    @(negedge clk); corr_dis = 1'b1;
    @(negedge clk); exp_pol(1'b0, "R10");
    @(negedge clk); corr_dis = 1'b0;
    @(negedge clk); exp_pol(1'b1, "R10");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule